// File: doc/BRIEF.md
# Program Fetch Wait-State Controller

This block sits between an instruction-fetch unit and three program-memory targets. Each 16-bit fetch address is sorted into one of three regions: a fast on-chip ROM at the bottom of the address space, a fast on-chip RAM at the top, and a slow off-chip memory for everything in between. The block presents the address to the selected target and returns the byte it reads. While an off-chip access is still in progress, it holds the fetch unit with a stall output.

On-chip fetches finish in the cycle they are requested. Off-chip fetches last for a number of wait states held in a small register that software can write. The off-chip memory can also hold its ready line low to stretch an access for as long as it needs. The block also carries program-memory writes, so that a boot loader can place code into the on-chip RAM. A write aimed at any other region is dropped and flagged.

Top module: `pfetch_wait_ctrl`

## Requirements
- R1: An address below ROM_SIZE (default 0x0400) selects on-chip ROM, and `rom_addr` carries its low bits. An address at or above RAM_BASE (default 0xF000) selects on-chip RAM, and `ram_addr` carries its offset from RAM_BASE. Every other address selects off-chip memory through `ext_addr`.
- R2: A fetch from either on-chip region never raises `fetch_stall`, whatever the level of `ext_ready`. `fetch_valid` is high in the following cycle, and `fetch_data` then holds the byte from the selected on-chip bus.
- R3: Number the cycle in which `fetch_req` is taken as cycle 0. An off-chip fetch completes in the first cycle k with k >= W and `ext_ready` high, where W is the wait-state count. `fetch_stall` is high in cycles 0 to k-1 and low in cycle k. `fetch_valid` and the `ext_rdata` byte follow one cycle after cycle k.
- R4: A low `ext_ready` lengthens an off-chip fetch for as many cycles as it stays low. A high `ext_ready` before cycle W does not end the fetch early.
- R5: The 3-bit wait-state count resets to 7. A write through `ws_we`/`ws_wdata` applies to fetches that start after the write cycle. It does not change a fetch that is already stalled.
- R6: With W = 0, an off-chip fetch that sees `ext_ready` high in its request cycle completes without any stall.
- R7: While a fetch is stalled, `fetch_req` is ignored. No second fetch starts, and only one `fetch_valid` pulse results.
- R8: A program write (`pm_wr`) whose address lies in the on-chip RAM region drives `ram_we` high in the same cycle. `ram_waddr` carries the RAM offset and `ram_wdata` carries the write data.
- R9: A program write to an address outside on-chip RAM leaves `ram_we` low and raises `pm_wr_err` for exactly one cycle, in the following cycle.
- R10: Out of reset, `fetch_stall`, `fetch_valid` and `pm_wr_err` are low.
- R11: During a stalled fetch, the memory address outputs keep the address of the accepted request even if `fetch_addr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 16 | Fetch address |
| ws_we | input | 1 | Write strobe for the wait-state count |
| ws_wdata | input | 3 | New wait-state count |
| ext_ready | input | 1 | Off-chip memory ready |
| rom_rdata | input | 8 | Byte from on-chip ROM |
| ram_rdata | input | 8 | Byte from on-chip RAM |
| ext_rdata | input | 8 | Byte from off-chip memory |
| rom_addr | output | 10 | On-chip ROM address |
| ram_addr | output | 12 | On-chip RAM read address |
| ext_addr | output | 16 | Off-chip memory address |
| fetch_stall | output | 1 | Holds the fetch unit |
| fetch_valid | output | 1 | Fetched byte is available |
| fetch_data | output | 8 | Fetched byte |
| pm_wr | input | 1 | Program-memory write request |
| pm_wr_addr | input | 16 | Program-memory write address |
| pm_wr_data | input | 8 | Program-memory write data |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_waddr | output | 12 | On-chip RAM write address |
| ram_wdata | output | 8 | On-chip RAM write data |
| pm_wr_err | output | 1 | One-cycle flag for a rejected write |

## Verification
Fetches target each region at its edge addresses: 0x0000, 0x03FF, 0x0400, 0xEFFF, 0xF000 and 0xFFFF. These separate a correct decode from an off-by-one at either boundary. Off-chip fetches are run with the ready line high from the start, low past the programmed count, and with a count of zero. Each pattern isolates one case: the count governs, the ready line governs, or the access completes at once. Further runs hold the request high during a stall, change the count in mid-fetch, and send writes to every region. These show that a stall cannot start a second fetch, that a new count takes effect only on the next fetch, and that only on-chip RAM accepts writes.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  typedef enum logic [1:0] {
    RGN_ROM = 2'd0,
    RGN_RAM = 2'd1,
    RGN_EXT = 2'd2
  } rgn_e;
endpackage

// File: rtl/pfw_region_decode.sv
module pfw_region_decode #(
  parameter int          ADDR_W   = 16,
  parameter int unsigned ROM_SIZE = 1024,
  parameter int unsigned RAM_BASE = 'hF000
) (
  input  logic [ADDR_W-1:0] addr,
  output pfw_pkg::rgn_e     rgn
);
  localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(ROM_SIZE);
  localparam logic [ADDR_W:0] RAM_LO  = (ADDR_W+1)'(RAM_BASE);

  logic below_rom;
  logic above_ram;

  always_comb begin
    below_rom = ({1'b0, addr} < ROM_LIM);
    above_ram = ({1'b0, addr} >= RAM_LO);
    if (below_rom)      rgn = pfw_pkg::RGN_ROM;
    else if (above_ram) rgn = pfw_pkg::RGN_RAM;
    else                rgn = pfw_pkg::RGN_EXT;
  end
endmodule

// File: rtl/pfw_ws_reg.sv
module pfw_ws_reg #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [WS_W-1:0] wdata,
  output logic [WS_W-1:0] ws
);
  logic [WS_W-1:0] ws_q, ws_d;

  always_comb begin
    ws_d = ws_q;
    if (we) ws_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_q <= '1;
    else        ws_q <= ws_d;
  end

  assign ws = ws_q;

  // R5 the count leaves reset at its largest value
  a_r5_reset_max: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ws_q == '1));
endmodule

// File: rtl/pfw_wait_seq.sv
module pfw_wait_seq #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_ext,
  input  logic [WS_W-1:0] ws_cfg,
  input  logic            ext_ready,
  output logic            busy,
  output logic            stall,
  output logic            done
);
  logic            busy_q, busy_d;
  logic [WS_W-1:0] cnt_q, cnt_d;
  logic [WS_W-1:0] cnt_load;
  logic            ws_zero;

  always_comb begin
    ws_zero  = (ws_cfg == '0);
    cnt_load = ws_zero ? '0 : WS_W'(ws_cfg - 1'b1);
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    done     = 1'b0;
    stall    = 1'b0;
    if (!busy_q) begin
      if (start) begin
        done  = !is_ext || (ws_zero && ext_ready);
        stall = !done;
        if (!done) begin
          busy_d = 1'b1;
          cnt_d  = cnt_load;
        end
      end
    end else begin
      done  = (cnt_q == '0) && ext_ready;
      stall = !done;
      if (cnt_q != '0)    cnt_d  = WS_W'(cnt_q - 1'b1);
      else if (ext_ready) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // checker state: stall cycles of the current fetch and its count
  logic [7:0]      run_q;
  logic [WS_W-1:0] ws_at_start_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q         <= '0;
      ws_at_start_q <= '0;
    end else begin
      if (start && !busy_q) ws_at_start_q <= ws_cfg;
      if (done)                   run_q <= '0;
      else if (stall && run_q != 8'hFF) run_q <= run_q + 8'd1;
    end
  end

  // R3 a stalled off-chip fetch lasts at least its programmed count
  a_r3_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy_q) |-> (run_q >= 8'(ws_at_start_q)));

  // R4 a low ready line keeps a stalled fetch stalled
  a_r4_ready_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ext_ready) |-> stall);

  // R7 a stalled fetch ends before another can begin
  a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done) |=> !busy_q);
endmodule

// File: rtl/pfw_wr_gate.sv
module pfw_wr_gate #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int unsigned ROM_SIZE = 1024,
  parameter int unsigned RAM_BASE = 'hF000,
  parameter int          RAM_AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              we,
  output logic [RAM_AW-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              err
);
  pfw_pkg::rgn_e wr_rgn;
  logic          err_q, err_d;

  pfw_region_decode #(
    .ADDR_W  (ADDR_W),
    .ROM_SIZE(ROM_SIZE),
    .RAM_BASE(RAM_BASE)
  ) u_wr_dec (
    .addr(wr_addr),
    .rgn (wr_rgn)
  );

  always_comb begin
    we    = wr && (wr_rgn == pfw_pkg::RGN_RAM);
    err_d = wr && (wr_rgn != pfw_pkg::RGN_RAM);
    waddr = wr_addr[RAM_AW-1:0];
    wdata = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

  // R9 a rejected write is flagged in the next cycle
  a_r9_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !we) |=> err);

  // R8 the error flag never follows an accepted write
  a_r8_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(wr) && !$past(we)));
endmodule

// File: rtl/pfetch_wait_ctrl.sv
module pfetch_wait_ctrl #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          WS_W     = 3,
  parameter int unsigned ROM_SIZE = 1024,
  parameter int unsigned RAM_BASE = 'hF000,
  localparam int         ROM_AW   = $clog2(ROM_SIZE),
  localparam int         RAM_AW   = $clog2((1 << ADDR_W) - RAM_BASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              ws_we,
  input  logic [WS_W-1:0]   ws_wdata,
  input  logic              ext_ready,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              fetch_stall,
  output logic              fetch_valid,
  output logic [DATA_W-1:0] fetch_data,
  input  logic              pm_wr,
  input  logic [ADDR_W-1:0] pm_wr_addr,
  input  logic [DATA_W-1:0] pm_wr_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              pm_wr_err
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WS_W-1:0]   ws_cur;
  logic              busy, done, start;
  logic [ADDR_W-1:0] addr_q, addr_d, cur_addr;
  pfw_pkg::rgn_e     cur_rgn;
  logic [DATA_W-1:0] data_q, data_d, sel_data;
  logic              valid_q;

  pfw_ws_reg #(.WS_W(WS_W)) u_ws (
    .clk  (clk),
    .rst_n(rst_int_n),
    .we   (ws_we),
    .wdata(ws_wdata),
    .ws   (ws_cur)
  );

  pfw_region_decode #(
    .ADDR_W  (ADDR_W),
    .ROM_SIZE(ROM_SIZE),
    .RAM_BASE(RAM_BASE)
  ) u_fetch_dec (
    .addr(cur_addr),
    .rgn (cur_rgn)
  );

  pfw_wait_seq #(.WS_W(WS_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .is_ext   (cur_rgn == pfw_pkg::RGN_EXT),
    .ws_cfg   (ws_cur),
    .ext_ready(ext_ready),
    .busy     (busy),
    .stall    (fetch_stall),
    .done     (done)
  );

  pfw_wr_gate #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ROM_SIZE(ROM_SIZE),
    .RAM_BASE(RAM_BASE),
    .RAM_AW  (RAM_AW)
  ) u_wr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr     (pm_wr),
    .wr_addr(pm_wr_addr),
    .wr_data(pm_wr_data),
    .we     (ram_we),
    .waddr  (ram_waddr),
    .wdata  (ram_wdata),
    .err    (pm_wr_err)
  );

  always_comb begin
    start    = fetch_req && !busy;
    cur_addr = busy ? addr_q : fetch_addr;
    addr_d   = start ? fetch_addr : addr_q;
    unique case (cur_rgn)
      pfw_pkg::RGN_ROM: sel_data = rom_rdata;
      pfw_pkg::RGN_RAM: sel_data = ram_rdata;
      default:          sel_data = ext_rdata;
    endcase
    data_d   = done ? sel_data : data_q;
    rom_addr = cur_addr[ROM_AW-1:0];
    ram_addr = cur_addr[RAM_AW-1:0];
    ext_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      data_q  <= data_d;
      valid_q <= done;
    end
  end

  assign fetch_valid = valid_q;
  assign fetch_data  = data_q;

  // R2 on-chip fetches never stall
  a_r2_onchip_no_stall: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && cur_rgn != pfw_pkg::RGN_EXT) |-> !fetch_stall);

  // R3 a completing fetch produces a valid byte in the next cycle
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fetch_req && !fetch_stall && !$past(fetch_stall) && !busy) |=> fetch_valid);

  // R11 the off-chip address is steady through a stall
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && $past(busy)) |-> $stable(ext_addr));
endmodule

// File: tb/pfetch_wait_ctrl_bench.sv
module pfetch_wait_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        ws_we;
  logic [2:0]  ws_wdata;
  logic        ext_ready;
  logic [7:0]  rom_rdata, ram_rdata, ext_rdata;
  logic [9:0]  rom_addr;
  logic [11:0] ram_addr;
  logic [15:0] ext_addr;
  logic        fetch_stall, fetch_valid;
  logic [7:0]  fetch_data;
  logic        pm_wr;
  logic [15:0] pm_wr_addr;
  logic [7:0]  pm_wr_data;
  logic        ram_we;
  logic [11:0] ram_waddr;
  logic [7:0]  ram_wdata;
  logic        pm_wr_err;

  always #4 clk = ~clk;

  pfetch_wait_ctrl u_pfetch_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .ws_we(ws_we), .ws_wdata(ws_wdata), .ext_ready(ext_ready),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .ext_rdata(ext_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ext_addr(ext_addr),
    .fetch_stall(fetch_stall), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .pm_wr(pm_wr), .pm_wr_addr(pm_wr_addr), .pm_wr_data(pm_wr_data),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .pm_wr_err(pm_wr_err)
  );

  // memory models: each byte is a fixed function of the address it sees
  function automatic logic [7:0] rom_fn(input logic [9:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] ram_fn(input logic [11:0] a);
    return {a[3:0], a[7:4]} ^ 8'hA5 ^ {4'h0, a[11:8]};
  endfunction
  function automatic logic [7:0] ext_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign rom_rdata = rom_fn(rom_addr);
  assign ram_rdata = ram_fn(ram_addr);
  assign ext_rdata = ext_fn(ext_addr);

  // expected region from R1: 0 rom, 1 ram, 2 off-chip
  function automatic int region_of(input logic [15:0] a);
    if (a < 16'h0400) return 0;
    if (a >= 16'hF000) return 1;
    return 2;
  endfunction
  function automatic logic [7:0] byte_of(input logic [15:0] a);
    case (region_of(a))
      0: return rom_fn(a[9:0]);
      1: return ram_fn(a[11:0]);
      default: return ext_fn(a);
    endcase
  endfunction

  typedef struct { logic [7:0] d; string tag; } exp_t;
  exp_t sb_q[$];

  int  checks = 0;
  int  errors = 0;
  bit  mon_on = 1'b0;
  bit  finished = 1'b0;
  int  ws_model = 7;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected byte per valid pulse
  always @(negedge clk) begin
    if (mon_on && fetch_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7", "valid with no fetch outstanding", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(fetch_data == e.d, e.tag, "fetched byte", fetch_data, e.d);
      end
    end
  end

  // driver: one fetch; ready rises in cycle rdy; optional mid-fetch count write
  task automatic do_fetch(input logic [15:0] a, input int rdy, input bit hold,
                          input int mid_k, input logic [2:0] mid_ws, input string tag);
    int   k;
    int   exp_stall;
    exp_t e;
    exp_stall = (region_of(a) == 2) ? ((ws_model > rdy) ? ws_model : rdy) : 0;
    e.d = byte_of(a);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    k = 0;
    forever begin
      ext_ready = (k >= rdy);
      ws_we     = (k == mid_k);
      ws_wdata  = mid_ws;
      #1;
      if (k > 0)
        check(ext_addr == a, "R11", "address held in stall", ext_addr, a);
      if (!fetch_stall) break;
      @(negedge clk);
      k++;
      fetch_req  = hold;
      fetch_addr = ~a;
      if (k > 40) break;
    end
    check(k == exp_stall, tag, "stall cycles", k, exp_stall);
    if (mid_k >= 0) ws_model = mid_ws;
    @(negedge clk);
    ws_we     = 1'b0;
    fetch_req = 1'b0;
    ext_ready = 1'b1;
  endtask

  task automatic set_ws(input logic [2:0] w);
    @(negedge clk);
    ws_we = 1'b1;
    ws_wdata = w;
    @(negedge clk);
    ws_we = 1'b0;
    ws_model = w;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    bit ok;
    ok = (region_of(a) == 1);
    @(negedge clk);
    pm_wr = 1'b1;
    pm_wr_addr = a;
    pm_wr_data = d;
    #1;
    if (ok) begin
      check(ram_we == 1'b1, "R8", "ram_we for RAM write", ram_we, 1);
      check(ram_waddr == a[11:0], "R8", "ram_waddr", ram_waddr, a[11:0]);
      check(ram_wdata == d, "R8", "ram_wdata", ram_wdata, d);
    end else begin
      check(ram_we == 1'b0, "R9", "ram_we for non-RAM write", ram_we, 0);
    end
    @(negedge clk);
    pm_wr = 1'b0;
    check(pm_wr_err == !ok, ok ? "R8" : "R9", "error flag next cycle", pm_wr_err, !ok);
    @(negedge clk);
    check(pm_wr_err == 1'b0, "R9", "error flag lasts one cycle", pm_wr_err, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    fetch_req = 1'b0; fetch_addr = '0;
    ws_we = 1'b0; ws_wdata = '0; ext_ready = 1'b1;
    pm_wr = 1'b0; pm_wr_addr = '0; pm_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(fetch_stall == 1'b0, "R10", "stall after reset", fetch_stall, 0);
    check(fetch_valid == 1'b0, "R10", "valid after reset", fetch_valid, 0);
    check(pm_wr_err == 1'b0, "R10", "error after reset", pm_wr_err, 0);
    mon_on = 1'b1;

    // region edges, on-chip with ready low for a while
    do_fetch(16'h0000, 0, 1'b0, -1, 3'd0, "R1");
    do_fetch(16'h03FF, 9, 1'b0, -1, 3'd0, "R2");
    do_fetch(16'hF000, 9, 1'b0, -1, 3'd0, "R2");
    do_fetch(16'hFFFF, 0, 1'b0, -1, 3'd0, "R1");
    // off-chip with reset count 7
    do_fetch(16'h0400, 0, 1'b0, -1, 3'd0, "R5");
    set_ws(3'd2);
    do_fetch(16'hEFFF, 0, 1'b0, -1, 3'd0, "R3");
    do_fetch(16'h1234, 5, 1'b0, -1, 3'd0, "R4");
    do_fetch(16'h5678, 0, 1'b1, -1, 3'd0, "R7");
    set_ws(3'd3);
    do_fetch(16'h0401, 0, 1'b0, -1, 3'd0, "R4");
    // count rewritten during a stall: old count still applies
    do_fetch(16'h2222, 0, 1'b0, 1, 3'd0, "R5");
    do_fetch(16'h3333, 0, 1'b0, -1, 3'd0, "R6");
    do_fetch(16'h4444, 2, 1'b0, -1, 3'd0, "R6");
    do_fetch(16'h0123, 0, 1'b0, -1, 3'd0, "R2");

    do_write(16'hF123, 8'h9C);
    do_write(16'hFFFF, 8'h01);
    do_write(16'h0010, 8'h77);
    do_write(16'h8000, 8'h66);
    do_write(16'hEFFF, 8'h55);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2", "all fetches returned", sb_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule